// File: doc/BRIEF.md
# Serial-Arithmetic FIR Filter

This block is a single-channel finite impulse response filter that uses little area. It spends several clock cycles on each input sample. It does not multiply whole samples. It takes a slice of bits from every stored sample in each cycle, multiplies the slices by the fixed coefficients, and adds the weighted partial sum into an accumulator. A mode parameter selects between two datapaths. The first takes one bit per cycle and needs one extra cycle to load the result. The second takes a group of several bits per cycle.

Samples arrive on a valid/ready stream and results leave on a second valid/ready stream. Neither stream carries packet framing. The filter takes a new sample once every N cycles and issues one result for each sample. N depends on the mode: the sample width plus one for single-bit processing, and the sample width divided by the group size for grouped processing. The result keeps full precision, so a parallel multiply-accumulate over the same taps gives the same bits.

Top module: `serial_fir`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. The tap history holds zeros.
- R2: A sample enters only on a rising edge where `in_valid` and `in_ready` are both 1. Data presented while `in_ready` is 0 has no effect on any result.
- R3: Single-bit mode, with the input always offered and the output always taken. Accepted samples are exactly DATA_W+1 cycles apart. `in_ready` is 1 for one cycle in each period and is 0 in the cycle after each acceptance.
- R4: Grouped mode, with the input always offered and the output always taken. Accepted samples are exactly DATA_W/UNITS cycles apart.
- R5: When the output register is free, `out_valid` rises after the Nth rising edge that follows the acceptance edge. The internal bit-slice counter stays within 0..N-1.
- R6: Each result equals the sum over k of c[k]·x[n−k]. Here x[n] is the sample just accepted, and c[k] is the signed COEF_W-bit field at bits k·COEF_W upward in COEFS, so tap 0 is in the low bits. Samples are DATA_W-bit two's complement and the sum is exact in OUT_W bits.
- R7: The most negative sample and coefficient values give exact results. The sign-bit slice is weighted negatively.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change. Every result is delivered once, in acceptance order.
- R9: The first results after reset use zeros for the taps that have not yet been filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Filter can take a sample this cycle |
| in_data | input | DATA_W | Two's-complement sample |
| out_valid | output | 1 | Result held in the output register |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | OUT_W | Full-precision two's-complement result |

## Verification
Take the edge that accepts a sample as edge 0. The result appears just after edge N: edge 9 for the single-bit instance and edge 4 for the grouped instance. The next sample is accepted on that same edge N. The bench records the cycle count of every accepting edge. The monitor samples at mid-cycle and compares the cycle in which `out_valid` first shows against the recorded count plus N. In streaming phases it also checks that consecutive accepting edges are exactly N apart. Under random output back-pressure the latency check is turned off. In that phase the monitor compares every held cycle against the value from the cycle before, and each popped value against the scoreboard.

// File: rtl/fir_ser_pkg.sv
`timescale 1ns/1ps
package fir_ser_pkg;

   typedef enum logic {
      SER_BIT   = 1'b0,
      SER_MULTI = 1'b1
   } ser_mode_e;

   function automatic int slice_width(ser_mode_e m, int units);
      return (m == SER_BIT) ? 1 : units;
   endfunction

   function automatic int cadence(ser_mode_e m, int data_w, int units);
      return (m == SER_BIT) ? data_w + 1 : data_w / units;
   endfunction

endpackage

// File: rtl/fir_ser_taps.sv
`timescale 1ns/1ps
module fir_ser_taps #(
   parameter int DATA_W = 8,
   parameter int TAPS   = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     shift,
   input  logic [DATA_W-1:0]        din,
   output logic [TAPS*DATA_W-1:0]   taps
);

   generate
      if (TAPS == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     taps <= '0;
            else if (shift) taps <= din;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     taps <= '0;
            else if (shift) taps <= {taps[(TAPS-1)*DATA_W-1:0], din};
         end
      end
   endgenerate

endmodule

// File: rtl/fir_ser_digit.sv
`timescale 1ns/1ps
module fir_ser_digit #(
   parameter int DATA_W = 8,
   parameter int COEF_W = 8,
   parameter int TAPS   = 4,
   parameter int U      = 1,
   parameter int NDIG   = 8,
   parameter int IDX_W  = 4,
   parameter int TERM_W = 12,
   parameter logic [TAPS*COEF_W-1:0] COEFS = '0
) (
   input  logic [TAPS*DATA_W-1:0]    taps,
   input  logic [IDX_W-1:0]          idx,
   output logic signed [TERM_W-1:0]  term
);

   logic signed [TERM_W-1:0] prod [TAPS];
   logic                     top_slice;

   assign top_slice = (int'(idx) == NDIG - 1);

   generate
      for (genvar k = 0; k < TAPS; k++) begin : g_tap
         logic [U-1:0]              slice;
         logic signed [U:0]         dig;
         logic signed [COEF_W-1:0]  cf;
         logic signed [COEF_W+U:0]  p;

         assign cf    = COEFS[k*COEF_W +: COEF_W];
         assign slice = taps[k*DATA_W + int'(idx)*U +: U];
         // the slice holding the sign bit carries negative weight
         assign dig   = top_slice ? {slice[U-1], slice} : {1'b0, slice};
         assign p     = cf * dig;
         assign prod[k] = TERM_W'(p);
      end
   endgenerate

   always_comb begin
      term = '0;
      for (int k = 0; k < TAPS; k++) term = term + prod[k];
   end

endmodule

// File: rtl/fir_ser_ctrl.sv
`timescale 1ns/1ps
module fir_ser_ctrl #(
   parameter  int N     = 9,
   localparam int CNT_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              out_free,
   output logic              in_ready,
   output logic              accept,
   output logic              step,
   output logic              fire,
   output logic              busy,
   output logic [CNT_W-1:0]  cnt
);

   logic last;

   assign last     = busy && (cnt == CNT_W'(N - 1));
   assign fire     = last && out_free;
   assign step     = busy && !last;
   assign in_ready = !busy || fire;
   assign accept   = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (accept) begin
         busy <= 1'b1;
         cnt  <= '0;
      end else if (fire) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (step) begin
         cnt  <= cnt + 1'b1;
      end
   end

   AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !in_ready) else $error("ready high right after acceptance"); // R3

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (int'(cnt) <= N - 1)) else $error("slice counter out of range"); // R5

   AST_FIRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (cnt == '0)) else $error("counter not restarted after load"); // R4

endmodule

// File: rtl/serial_fir.sv
`timescale 1ns/1ps
module serial_fir
   import fir_ser_pkg::*;
#(
   parameter ser_mode_e MODE   = SER_BIT,
   parameter int        DATA_W = 8,
   parameter int        COEF_W = 8,
   parameter int        TAPS   = 4,
   parameter int        UNITS  = 2,
   parameter logic [TAPS*COEF_W-1:0] COEFS = 32'hFB7F_8003,
   localparam int       OUT_W  = DATA_W + COEF_W + $clog2(TAPS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [DATA_W-1:0]  in_data,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [OUT_W-1:0]   out_data
);

   localparam int U_EFF  = slice_width(MODE, UNITS);
   localparam int NDIG   = DATA_W / U_EFF;
   localparam int N      = cadence(MODE, DATA_W, UNITS);
   localparam int CNT_W  = (N > 1) ? $clog2(N) : 1;
   localparam int TERM_W = COEF_W + U_EFF + 1 + $clog2(TAPS);

   generate
      if (MODE == SER_MULTI && (DATA_W % UNITS) != 0) begin : g_bad_units
         $error("DATA_W must be a multiple of UNITS");
      end
      if (N < 2) begin : g_bad_cadence
         $error("cadence must be at least two cycles");
      end
      if (TAPS < 1) begin : g_bad_taps
         $error("TAPS must be at least one");
      end
   endgenerate

   logic                      accept, step, fire, busy, out_free;
   logic [CNT_W-1:0]          cnt;
   logic [CNT_W-1:0]          dig_idx;
   logic [TAPS*DATA_W-1:0]    taps;
   logic signed [TERM_W-1:0]  term;
   logic signed [OUT_W-1:0]   term_ext, shifted, acc, final_sum;

   assign out_free = !out_valid || out_ready;

   fir_ser_ctrl #(.N(N)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .out_free (out_free),
      .in_ready (in_ready),
      .accept   (accept),
      .step     (step),
      .fire     (fire),
      .busy     (busy),
      .cnt      (cnt)
   );

   fir_ser_taps #(.DATA_W(DATA_W), .TAPS(TAPS)) u_taps (
      .clk   (clk),
      .rst_n (rst_n),
      .shift (accept),
      .din   (in_data),
      .taps  (taps)
   );

   assign dig_idx = (int'(cnt) < NDIG) ? cnt : '0;

   fir_ser_digit #(
      .DATA_W (DATA_W), .COEF_W (COEF_W), .TAPS (TAPS), .U (U_EFF),
      .NDIG (NDIG), .IDX_W (CNT_W), .TERM_W (TERM_W), .COEFS (COEFS)
   ) u_digit (
      .taps (taps),
      .idx  (dig_idx),
      .term (term)
   );

   assign term_ext = OUT_W'(term);
   assign shifted  = term_ext <<< (int'(dig_idx) * U_EFF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      acc <= '0;
      else if (accept) acc <= '0;
      else if (step)   acc <= acc + shifted;
   end

   generate
      if (MODE == SER_BIT) begin : g_bit
         // slices finish one cycle early; the spare cycle only loads the result
         assign final_sum = acc;
      end else begin : g_multi
         // last slice is added on the way into the output register
         assign final_sum = acc + shifted;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else if (fire) begin
         out_valid <= 1'b1;
         out_data  <= final_sum;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   logic [CNT_W:0] since_acc;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       since_acc <= '0;
      else if (accept)                  since_acc <= '0;
      else if (int'(since_acc) < N)     since_acc <= since_acc + 1'b1;
   end

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data))
      else $error("held result changed"); // R8

   AST_LOAD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> busy && (int'(since_acc) >= N - 1))
      else $error("result loaded too early"); // R5

endmodule

// File: tb/serial_fir_tb.sv
`timescale 1ns/1ps
module serial_fir_tb;
   import fir_ser_pkg::*;

   localparam int DW = 8, CW = 8, T = 4, U = 2;
   localparam int AW = DW + CW + $clog2(T);
   localparam logic [T*CW-1:0] CF = 32'hFB7F_8003;
   localparam int NB = DW + 1;
   localparam int NM = DW / U;

   logic clk = 1'b0, rst_n = 1'b0;
   always #2 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   logic          bs_in_valid = 0, bs_out_ready = 0, bs_in_ready, bs_out_valid;
   logic [DW-1:0] bs_in_data = '0;
   logic [AW-1:0] bs_out_data;
   logic          mb_in_valid = 0, mb_out_ready = 0, mb_in_ready, mb_out_valid;
   logic [DW-1:0] mb_in_data = '0;
   logic [AW-1:0] mb_out_data;

   serial_fir #(.MODE(SER_BIT), .DATA_W(DW), .COEF_W(CW), .TAPS(T), .UNITS(U), .COEFS(CF)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(bs_in_valid), .in_ready(bs_in_ready), .in_data(bs_in_data),
      .out_valid(bs_out_valid), .out_ready(bs_out_ready), .out_data(bs_out_data));

   serial_fir #(.MODE(SER_MULTI), .DATA_W(DW), .COEF_W(CW), .TAPS(T), .UNITS(U), .COEFS(CF)) u_dut_mb (
      .clk(clk), .rst_n(rst_n), .in_valid(mb_in_valid), .in_ready(mb_in_ready), .in_data(mb_in_data),
      .out_valid(mb_out_valid), .out_ready(mb_out_ready), .out_data(mb_out_data));

   int    checks = 0, errors = 0;
   string req = "R1";
   bit    lat_chk = 0, strm_chk = 0, bp_mode = 0;
   logic [15:0] lfsr = 16'hACE1;
   int    hist [2][T];
   int    last_acc [2];
   logic signed [AW-1:0] q0 [$], q1 [$];
   int    c0 [$], c1 [$];
   bit    prev_v [2], prev_r [2];
   logic [AW-1:0] prev_d [2];

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int coef(input int k);
      logic signed [CW-1:0] c;
      c = CF[k*CW +: CW];
      return int'(c);
   endfunction

   task automatic send(input int w, input logic [DW-1:0] d);
      longint s;
      int acyc;
      logic signed [DW-1:0] sd;
      @(negedge clk); #0.5;
      if (w == 0) begin
         bs_in_valid = 1'b1;
         bs_in_data  = d ^ 8'hA5;
         while (!bs_in_ready) begin @(negedge clk); #0.5; end
         bs_in_data  = d;
      end else begin
         mb_in_valid = 1'b1;
         mb_in_data  = d ^ 8'hA5;
         while (!mb_in_ready) begin @(negedge clk); #0.5; end
         mb_in_data  = d;
      end
      acyc = cyc + 1;
      @(posedge clk); #0.5;
      if (w == 0) begin bs_in_valid = 1'b0; bs_in_data = ~d; end
      else        begin mb_in_valid = 1'b0; mb_in_data = ~d; end
      if (strm_chk && last_acc[w] >= 0)
         check(acyc - last_acc[w] == ((w == 0) ? NB : NM),
               (w == 0) ? "R3 acceptance spacing" : "R4 acceptance spacing",
               acyc - last_acc[w], (w == 0) ? NB : NM);
      last_acc[w] = acyc;
      for (int k = T - 1; k > 0; k--) hist[w][k] = hist[w][k-1];
      sd = d;
      hist[w][0] = int'(sd);
      s = 0;
      for (int k = 0; k < T; k++) s += longint'(coef(k)) * longint'(hist[w][k]);
      if (w == 0) begin q0.push_back(AW'(s)); c0.push_back(acyc); end
      else        begin q1.push_back(AW'(s)); c1.push_back(acyc); end
   endtask

   always @(negedge clk) begin
      #0.25;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      bs_out_ready = bp_mode ? lfsr[0] : 1'b1;
      mb_out_ready = bp_mode ? lfsr[3] : 1'b1;
   end

   task automatic mon(input int w);
      logic v, r;
      logic [AW-1:0] dt;
      logic signed [AW-1:0] e, sdt;
      int ac, n;
      bit empty;
      v = (w == 0) ? bs_out_valid : mb_out_valid;
      r = (w == 0) ? bs_out_ready : mb_out_ready;
      dt = (w == 0) ? bs_out_data : mb_out_data;
      n = (w == 0) ? NB : NM;
      sdt = dt;
      if (prev_v[w] && !prev_r[w])
         check(v && dt == prev_d[w], "R8 held result", longint'(sdt), longint'($signed(prev_d[w])));
      if (v && r) begin
         empty = (w == 0) ? (q0.size() == 0) : (q1.size() == 0);
         if (empty) check(1'b0, {req, " unexpected result"}, longint'(sdt), 0);
         else begin
            if (w == 0) begin e = q0.pop_front(); ac = c0.pop_front(); end
            else        begin e = q1.pop_front(); ac = c1.pop_front(); end
            check(sdt === e, {req, " result value"}, longint'(sdt), longint'(e));
            if (lat_chk && !prev_v[w])
               check(cyc - ac == n, "R5 result latency", cyc - ac, n);
         end
      end
      prev_v[w] = v;
      prev_r[w] = r;
      prev_d[w] = dt;
   endtask

   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         mon(0);
         mon(1);
      end
   end

   task automatic drain();
      for (int i = 0; i < 3000; i++) begin
         if (q0.size() == 0 && q1.size() == 0) break;
         @(posedge clk);
      end
      repeat (3) @(posedge clk);
      check(q0.size() == 0 && q1.size() == 0, "R8 all results delivered", q0.size() + q1.size(), 0);
   endtask

   task automatic stream(input int cnt, input int kind);
      fork
         begin
            for (int i = 0; i < cnt; i++)
               send(0, (kind == 0) ? DW'(i*37 + 5) : DW'((i*i*13) ^ 8'h3C));
         end
         begin
            for (int i = 0; i < cnt; i++)
               send(1, (kind == 0) ? DW'(200 - i*29) : DW'((i*71) ^ 8'hC3));
         end
      join
   endtask

   bit finished = 0;

   initial begin
      for (int w = 0; w < 2; w++) begin
         last_acc[w] = -1;
         prev_v[w] = 0; prev_r[w] = 0; prev_d[w] = '0;
         for (int k = 0; k < T; k++) hist[w][k] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      check(bs_in_ready === 1'b1, "R1 ready after reset (bit)", bs_in_ready, 1);
      check(bs_out_valid === 1'b0, "R1 valid after reset (bit)", bs_out_valid, 0);
      check(mb_in_ready === 1'b1, "R1 ready after reset (group)", mb_in_ready, 1);
      check(mb_out_valid === 1'b0, "R1 valid after reset (group)", mb_out_valid, 0);

      // R9 first result uses zero history
      req = "R9"; lat_chk = 1;
      send(0, 8'h7F);
      send(1, 8'h7F);
      drain();

      // R6 and R2: streaming, junk data whenever ready is low
      req = "R6/R2"; strm_chk = 1;
      last_acc[0] = -1; last_acc[1] = -1;
      stream(12, 0);
      drain();
      last_acc[0] = -1; last_acc[1] = -1;
      stream(12, 1);
      drain();

      // R7 extreme negative values
      req = "R7";
      last_acc[0] = -1; last_acc[1] = -1;
      fork
         begin
            send(0, 8'h80); send(0, 8'h80); send(0, 8'h7F); send(0, 8'h80);
            send(0, 8'h80); send(0, 8'h00); send(0, 8'hFF); send(0, 8'h01);
         end
         begin
            send(1, 8'h80); send(1, 8'h80); send(1, 8'h7F); send(1, 8'h80);
            send(1, 8'h80); send(1, 8'h00); send(1, 8'hFF); send(1, 8'h01);
         end
      join
      drain();

      // R8 output back-pressure
      req = "R8"; strm_chk = 0; lat_chk = 0; bp_mode = 1;
      stream(16, 1);
      drain();
      bp_mode = 0;

      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         check(1'b0, "watchdog expired", cyc, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule